// File: doc/BRIEF.md
# Channel wake event interrupt queue

This block gathers per-channel wake events from a service side and reports them to a host driver through one interrupt line and two read-only registers. Each channel slot can see three kinds of event: the channel became readable, it became writable, or the service closed it. Readable and writable events are kept only when the driver armed a wake request of that kind for the channel beforehand. Closed events are always kept.

While any channel holds a pending event, the interrupt line is high. The interrupt handler then drains the queue. A read of the channel register selects the lowest-numbered pending slot and returns its identifier, which is the slot index plus one. A read of the mask register then returns that channel's event bits and clears them. The handler repeats this until the channel register returns zero. Identifier zero is reserved as the end-of-list marker.

Top module: `wake_irq_queue`

## Requirements
- R1: After reset the interrupt line is low, and both register outputs read zero. No wake request is armed.
- R2: A closed pulse on a slot is always recorded as pending, whatever the arming state of that slot.
- R3: A readable pulse is recorded only when wake-on-read was armed for that slot on an earlier cycle. An arm request in the same cycle as the pulse does not admit it, and a pulse that is not admitted leaves no trace.
- R4: A writable pulse is recorded only when wake-on-write was armed for that slot on an earlier cycle. Otherwise it is dropped.
- R5: The interrupt line is high whenever at least one slot holds a pending bit. It goes low on the cycle after the mask read that clears the last pending bit.
- R6: One cycle after a channel-register read strobe, the channel output shows the lowest-indexed pending slot as index plus one. If nothing is pending, it shows 0.
- R7: One cycle after a mask-register read strobe, the mask output shows the pending bits of the selected channel, with bit 0 closed, bit 1 readable and bit 2 writable. Those pending bits are cleared by the same read.
- R8: A mask read disarms only the wake requests whose bits it reported. An armed request whose bit was not reported stays armed.
- R9: A pulse for a bit that is already pending merges into that bit, so the channel appears once in the list.
- R10: A pulse that reaches a slot in the same cycle as the mask read draining that slot stays pending. The interrupt line therefore stays high, and the channel is listed again.
- R11: Arm requests that carry channel 0, or a channel above the slot count, have no effect.
- R12: A mask read that has no selected channel, for example after the channel register returned 0, returns 0 and changes no pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_cls | input | NUM_CH | Per-slot closed event pulses |
| evt_rd | input | NUM_CH | Per-slot readable event pulses |
| evt_wr | input | NUM_CH | Per-slot writable event pulses |
| arm_valid | input | 1 | Arm request strobe |
| arm_write | input | 1 | 1 arms wake-on-write, 0 arms wake-on-read |
| arm_chan | input | ID_W | Channel identifier (slot + 1) of the arm request |
| chan_rd | input | 1 | Read strobe of the channel register |
| wakes_rd | input | 1 | Read strobe of the mask register |
| chan_data | output | ID_W | Channel register value, 0 ends the list |
| wakes_data | output | 3 | Mask register value |
| irq | output | 1 | Interrupt, high while any event is pending |

## Verification
The drain of a slot and a fresh event on that same slot can fall in the same cycle. That collision decides whether an event is lost between a mask read and the next channel read. The bench provokes it by raising a closed pulse on the exact cycle the mask read strobe is sampled. It then judges the outcome by three observations: the returned mask holds only the earlier bits, the interrupt stays high, and the next channel read names the same slot again. A second overlap, an arm request landing with its event, is checked by verifying that the interrupt stays low.

// File: rtl/wakeq_pkg.sv
package wakeq_pkg;

    // Event mask: bit 0 closed, bit 1 readable, bit 2 writable
    typedef struct packed {
        logic wr;
        logic rd;
        logic cls;
    } wake_mask_t;

    localparam int MASK_W = 3;

    localparam wake_mask_t MASK_NONE = '{wr: 1'b0, rd: 1'b0, cls: 1'b0};

    // Admit raw service pulses through the arming gates
    function automatic wake_mask_t admit(input logic cls, input logic rd,
                                         input logic wr, input logic arm_rd,
                                         input logic arm_wr);
        wake_mask_t m;
        m.cls = cls;
        m.rd  = rd & arm_rd;
        m.wr  = wr & arm_wr;
        return m;
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wakeq_slot.sv
module wakeq_slot
    import wakeq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ev_cls,
    input  logic       ev_rd,
    input  logic       ev_wr,
    input  logic       arm_rd_set,
    input  logic       arm_wr_set,
    input  logic       drain,
    output wake_mask_t pend,
    output logic       armed_rd,
    output logic       armed_wr
);

    wake_mask_t pend_q;
    wake_mask_t incoming;
    logic       arm_rd_q, arm_wr_q;

    assign incoming = admit(ev_cls, ev_rd, ev_wr, arm_rd_q, arm_wr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= MASK_NONE;
            arm_rd_q <= 1'b0;
            arm_wr_q <= 1'b0;
        end else begin
            // new arrivals win over the drain of the same cycle
            pend_q   <= (drain ? MASK_NONE : pend_q) | incoming;
            arm_rd_q <= (arm_rd_q & ~(drain & pend_q.rd)) | arm_rd_set;
            arm_wr_q <= (arm_wr_q & ~(drain & pend_q.wr)) | arm_wr_set;
        end
    end

    assign pend     = pend_q;
    assign armed_rd = arm_rd_q;
    assign armed_wr = arm_wr_q;

    p_rd_gated_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q.rd) |-> $past(arm_rd_q));

    p_wr_gated_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q.wr) |-> $past(arm_wr_q));

    p_cls_kept_r2: assert property (@(posedge clk) disable iff (rst)
        ev_cls |=> pend_q.cls);

endmodule

// File: rtl/wakeq_pick.sv
module wakeq_pick #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned IDX_W  = 2
) (
    input  logic [NUM_CH-1:0] req,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);

    // lowest index wins: scan downward so the last hit is the smallest
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/wake_irq_queue.sv
module wake_irq_queue
    import wakeq_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ID_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] evt_cls,
    input  logic [NUM_CH-1:0] evt_rd,
    input  logic [NUM_CH-1:0] evt_wr,
    input  logic              arm_valid,
    input  logic              arm_write,
    input  logic [ID_W-1:0]   arm_chan,
    input  logic              chan_rd,
    input  logic              wakes_rd,
    output logic [ID_W-1:0]   chan_data,
    output logic [2:0]        wakes_data,
    output logic              irq
);

    localparam int unsigned IDX_W = idx_width(NUM_CH);

    wake_mask_t        pend [NUM_CH];
    logic [NUM_CH-1:0] pend_any;
    logic [NUM_CH-1:0] drain_vec;
    logic [NUM_CH-1:0] arm_rd_vec, arm_wr_vec;
    logic [NUM_CH-1:0] armed_rd_vec, armed_wr_vec;

    logic              pick_found;
    logic [IDX_W-1:0]  pick_idx;

    logic              cur_valid;
    logic [IDX_W-1:0]  cur_idx;
    logic [ID_W-1:0]   chan_q;
    wake_mask_t        mask_q;
    wake_mask_t        cur_mask;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        assign arm_rd_vec[g] = arm_valid && !arm_write && (arm_chan == ID_W'(g + 1));
        assign arm_wr_vec[g] = arm_valid &&  arm_write && (arm_chan == ID_W'(g + 1));
        assign drain_vec[g]  = wakes_rd && cur_valid && (cur_idx == IDX_W'(g));
        assign pend_any[g]   = |pend[g];

        wakeq_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .ev_cls    (evt_cls[g]),
            .ev_rd     (evt_rd[g]),
            .ev_wr     (evt_wr[g]),
            .arm_rd_set(arm_rd_vec[g]),
            .arm_wr_set(arm_wr_vec[g]),
            .drain     (drain_vec[g]),
            .pend      (pend[g]),
            .armed_rd  (armed_rd_vec[g]),
            .armed_wr  (armed_wr_vec[g])
        );
    end

    wakeq_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
        .req  (pend_any),
        .found(pick_found),
        .idx  (pick_idx)
    );

    always_comb begin
        cur_mask = MASK_NONE;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cur_idx == IDX_W'(i)) cur_mask = pend[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_valid <= 1'b0;
            cur_idx   <= '0;
            chan_q    <= '0;
            mask_q    <= MASK_NONE;
        end else begin
            if (chan_rd) begin
                cur_valid <= pick_found;
                cur_idx   <= pick_idx;
                chan_q    <= pick_found ? ID_W'(pick_idx) + ID_W'(1) : '0;
            end else if (wakes_rd) begin
                cur_valid <= 1'b0;
                mask_q    <= cur_valid ? cur_mask : MASK_NONE;
            end
        end
    end

    assign chan_data  = chan_q;
    assign wakes_data = mask_q;
    assign irq        = |pend_any;

    p_irq_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|{evt_cls, evt_rd, evt_wr}));

    p_irq_fall_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(wakes_rd));

    p_chan_range_r6: assert property (@(posedge clk) disable iff (rst)
        chan_data <= ID_W'(NUM_CH));

    p_blind_read_r12: assert property (@(posedge clk) disable iff (rst)
        (wakes_rd && !chan_rd && !cur_valid) |=> (wakes_data == 3'b000));

endmodule

// File: tb/wake_irq_queue_test.sv
`timescale 1ns/1ps
module wake_irq_queue_test;

    localparam int N  = 4;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  evt_cls = '0, evt_rd = '0, evt_wr = '0;
    logic          arm_valid = 1'b0, arm_write = 1'b0;
    logic [IW-1:0] arm_chan = '0;
    logic          chan_rd = 1'b0, wakes_rd = 1'b0;
    logic [IW-1:0] chan_data;
    logic [2:0]    wakes_data;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    wake_irq_queue #(.NUM_CH(N), .ID_W(IW)) uut (
        .clk(clk), .rst(rst),
        .evt_cls(evt_cls), .evt_rd(evt_rd), .evt_wr(evt_wr),
        .arm_valid(arm_valid), .arm_write(arm_write), .arm_chan(arm_chan),
        .chan_rd(chan_rd), .wakes_rd(wakes_rd),
        .chan_data(chan_data), .wakes_data(wakes_data), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic arm(input int ch, input bit wr);
        arm_valid = 1'b1; arm_write = wr; arm_chan = IW'(ch);
        @(negedge clk);
        arm_valid = 1'b0; arm_write = 1'b0; arm_chan = '0;
    endtask

    task automatic pulse(input int slot, input logic [2:0] m);
        evt_cls[slot] = m[0]; evt_rd[slot] = m[1]; evt_wr[slot] = m[2];
        @(negedge clk);
        evt_cls = '0; evt_rd = '0; evt_wr = '0;
    endtask

    task automatic rd_chan(output int v);
        chan_rd = 1'b1;
        @(negedge clk);
        chan_rd = 1'b0;
        v = int'(chan_data);
    endtask

    task automatic rd_wakes(output int v);
        wakes_rd = 1'b1;
        @(negedge clk);
        wakes_rd = 1'b0;
        v = int'(wakes_data);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", int'(irq), 0);
        chk("R1 chan", int'(chan_data), 0);
        chk("R1 mask", int'(wakes_data), 0);
        pulse(0, 3'b110);
        chk("R1 nothing armed", int'(irq), 0);

        // R2 R3 R4 R7 R8: every slot, arming pattern and event pattern
        for (int s = 0; s < N; s++) begin
            for (int a = 0; a < 4; a++) begin
                for (int e = 0; e < 8; e++) begin
                    int exp_m, left_rd, left_wr, exp2;
                    if (a[0]) arm(s + 1, 1'b0);
                    if (a[1]) arm(s + 1, 1'b1);
                    pulse(s, 3'(e));
                    exp_m = (e & 1) | ((e & 2) & (a[0] ? 2 : 0)) | ((e & 4) & (a[1] ? 4 : 0));
                    chk("R5 irq level", int'(irq), exp_m != 0 ? 1 : 0);
                    rd_chan(v);
                    chk("R6 channel id", v, exp_m != 0 ? s + 1 : 0);
                    rd_wakes(v);
                    chk("R7 mask R2 R3 R4 gating", v, exp_m);
                    chk("R5 irq after drain", int'(irq), 0);
                    // R8 leftover arming
                    left_rd = (a[0] && !(exp_m & 2)) ? 1 : 0;
                    left_wr = (a[1] && !(exp_m & 4)) ? 1 : 0;
                    exp2 = (left_rd << 1) | (left_wr << 2);
                    pulse(s, 3'b110);
                    rd_chan(v);
                    chk("R8 leftover id", v, exp2 != 0 ? s + 1 : 0);
                    rd_wakes(v);
                    chk("R8 leftover arming", v, exp2);
                end
            end
        end

        // R6 ascending order across all slot subsets
        for (int p = 1; p < (1 << N); p++) begin
            evt_cls = N'(p);
            @(negedge clk);
            evt_cls = '0;
            for (int s = 0; s < N; s++) begin
                if (p[s]) begin
                    rd_chan(v);
                    chk("R6 ascending order", v, s + 1);
                    rd_wakes(v);
                    chk("R7 closed bit", v, 1);
                end
            end
            rd_chan(v);
            chk("R6 end of list", v, 0);
            chk("R5 irq low", int'(irq), 0);
        end

        // R9 merge of repeated events
        pulse(2, 3'b001);
        pulse(2, 3'b001);
        rd_chan(v);  chk("R9 merged id", v, 3);
        rd_wakes(v); chk("R9 merged mask", v, 1);
        rd_chan(v);  chk("R9 listed once", v, 0);

        // R3 arm in the same cycle as the event does not admit it
        evt_rd[1] = 1'b1; arm_valid = 1'b1; arm_chan = IW'(2);
        @(negedge clk);
        evt_rd = '0; arm_valid = 1'b0; arm_chan = '0;
        chk("R3 same-cycle arm", int'(irq), 0);
        pulse(1, 3'b010);
        rd_chan(v);  chk("R3 later admitted id", v, 2);
        rd_wakes(v); chk("R3 later admitted mask", v, 2);

        // R10 event colliding with the drain of the same slot
        pulse(1, 3'b001);
        rd_chan(v);  chk("R10 id", v, 2);
        wakes_rd = 1'b1; evt_cls[1] = 1'b1;
        @(negedge clk);
        wakes_rd = 1'b0; evt_cls = '0;
        chk("R10 drained mask", int'(wakes_data), 1);
        chk("R10 irq held", int'(irq), 1);
        rd_chan(v);  chk("R10 relisted", v, 2);
        rd_wakes(v); chk("R10 relisted mask", v, 1);
        chk("R10 irq low", int'(irq), 0);

        // R11 out-of-range arm requests
        arm(0, 1'b0); arm(0, 1'b1); arm(N + 1, 1'b0); arm(N + 1, 1'b1);
        for (int s = 0; s < N; s++) pulse(s, 3'b110);
        chk("R11 ignored arms", int'(irq), 0);
        rd_chan(v); chk("R11 empty list", v, 0);

        // R12 blind mask read
        pulse(2, 3'b001);
        rd_wakes(v); chk("R12 blind mask", v, 0);
        chk("R12 irq kept", int'(irq), 1);
        rd_chan(v);  chk("R12 still listed", v, 3);
        rd_wakes(v); chk("R12 mask intact", v, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule